// File: doc/BRIEF.md
# Nibble-Indexed Cartridge Mapper Controller

This block is a cartridge-side memory controller on an 8-bit CPU bus. The host reaches it through a two-location window inside the address region whose top three bits are `101`. The odd location is an index port and the even location is a data port. Each data-port write stores one 4-bit value into a small register file, at the slot the index selects. Those slots hold the ROM bank number, the byte to store, a control nibble and the low nibble of a save-RAM address. The block drives the bank number straight to the ROM decoder and keeps a 32-byte save RAM.

A save-RAM store takes effect when the address-low slot is written while the control mode is "store". To fetch a byte, the host sets the control mode to "fetch" and writes the address-low slot, which changes no RAM contents. It then points the index at one of two read selectors and reads the chosen nibble through the data port. The nibble comes back with the upper four bits set to ones. Reads are combinational from the current state and depend only on address bit 0. Decoding the read region is left to the surrounding bus logic.

Top module: `nibble_mapper`

## Requirements
- R1: A synchronous active-high reset clears the index, all eight nibble slots, the bank output and every save-RAM byte to zero.
- R2: A write is taken only when `bus_we` is high and `bus_addr[15:13]` is `3'b101`. A write to any other address changes no state.
- R3: A write with `bus_addr[0]` = 1 stores the whole data byte as the current index. No unlock sequence is needed.
- R4: A write with `bus_addr[0]` = 0 stores `bus_wdata[3:0]` into slot `index` when the index is below 8. The upper data bits are dropped, and with an index of 8 or more the write changes nothing.
- R5: `rom_bank` equals {slot 1, slot 0}. It takes the new value on the clock edge of a data write to slot 0 or slot 1 and does not change otherwise.
- R6: A data write to slot 7 while control bits [3:1] (slot 6) are 0 stores the byte {slot 5, slot 4} into save RAM. The address is {slot 6 bit 0, the nibble just written to slot 7}.
- R7: A data write to slot 7 with control bits [3:1] not equal to 0 leaves the save RAM unchanged. Data writes to slots 4, 5 and 6 never change the save RAM.
- R8: A read with `bus_addr[0]` = 1 returns 0xFF.
- R9: A read with `bus_addr[0]` = 0 returns 0xF1 when the index is 0x0A. It also returns 0xF1 for every index other than 0x0C and 0x0D.
- R10: With index 0x0C (low nibble) or 0x0D (high nibble) and control bits [3:1] equal to 1, a data-port read returns 0xF0 ORed with that nibble of the RAM byte at {slot 6 bit 0, slot 7}. With any other control value it returns 0xF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe for the current bus cycle |
| bus_addr | input | 16 | CPU bus address |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Read data for the window, selected by bus_addr[0] |
| rom_bank | output | 8 | Selected ROM bank number |

## Verification
Save-RAM traffic is tried at address 0x00, 0x0F, 0x10 and 0x1F, with data bytes whose two nibbles differ. These cases tell the address MSB taken from slot 6 apart from the slot 7 nibble, and the low read selector apart from the high one. Commits in fetch mode and in an undefined mode are issued with fresh write data, and then the old byte is read back. This shows that only mode 0 stores. The bank is written one nibble at a time to show the order of the two nibbles. Writes outside the region and at indexes 8 and 0x10 are used to catch a decoder or index check that looks at too few bits.

// File: rtl/nibmap_pkg.sv
package nibmap_pkg;
    localparam int unsigned NIB_W   = 4;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned BUS_AW  = 16;
    localparam int unsigned REG_NUM = 8;
    localparam int unsigned SEL_W   = $clog2(REG_NUM);
    localparam int unsigned SRAM_AW = NIB_W + 1;

    localparam logic [2:0] WIN_REGION = 3'b101;

    // slot positions inside the nibble register file
    localparam int SLOT_BANK_LO = 0;
    localparam int SLOT_BANK_HI = 1;
    localparam int SLOT_DAT_LO  = 4;
    localparam int SLOT_DAT_HI  = 5;
    localparam int SLOT_CTRL    = 6;
    localparam int SLOT_ADR_LO  = 7;

    // index values seen on the bus
    localparam logic [BYTE_W-1:0] IX_ADR_LO = 8'h07;
    localparam logic [BYTE_W-1:0] IX_STATUS = 8'h0A;
    localparam logic [BYTE_W-1:0] IX_RD_LO  = 8'h0C;
    localparam logic [BYTE_W-1:0] IX_RD_HI  = 8'h0D;

    typedef enum logic [2:0] {
        MODE_STORE = 3'd0,
        MODE_FETCH = 3'd1
    } sram_mode_e;

    localparam logic [BYTE_W-1:0] RD_IDX_PORT = 8'hFF;
    localparam logic [BYTE_W-1:0] RD_STATUS   = 8'hF1;
    localparam logic [BYTE_W-1:0] RD_PAD      = 8'hF0;
endpackage

// File: rtl/nibmap_decode.sv
module nibmap_decode
    import nibmap_pkg::*;
#(
    parameter int unsigned AW = BUS_AW
) (
    input  logic          we,
    input  logic [AW-1:0] addr,
    output logic          idx_wr,
    output logic          dat_wr
);
    logic in_win;

    always_comb begin
        in_win = (addr[AW-1 -: 3] == WIN_REGION);
        idx_wr = we && in_win && addr[0];
        dat_wr = we && in_win && !addr[0];
    end
endmodule

// File: rtl/nibmap_regfile.sv
module nibmap_regfile
    import nibmap_pkg::*;
#(
    parameter int unsigned NW   = NIB_W,
    parameter int unsigned IW   = BYTE_W,
    parameter int unsigned NREG = REG_NUM
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idx_wr,
    input  logic              dat_wr,
    input  logic [IW-1:0]     wdata,
    output logic [IW-1:0]     idx_o,
    output logic [2*NW-1:0]   bank_o,
    output logic [NW-1:0]     ctrl_o,
    output logic [NW:0]       raddr_o,
    output logic              ram_we,
    output logic [NW:0]       ram_waddr,
    output logic [2*NW-1:0]   ram_wdata
);
    localparam int unsigned SW = $clog2(NREG);
    localparam logic [IW-1:0] REG_LIM = IW'(NREG);

    typedef struct packed {
        logic [IW-1:0]          idx;
        logic [NREG-1:0][NW-1:0] slots;
    } rf_state_t;

    rf_state_t st_d, st_q;
    logic      slot_ok;

    always_comb begin
        st_d      = st_q;
        slot_ok   = (st_q.idx < REG_LIM);
        ram_we    = 1'b0;
        if (idx_wr) begin
            st_d.idx = wdata;
        end else if (dat_wr && slot_ok) begin
            st_d.slots[st_q.idx[SW-1:0]] = wdata[NW-1:0];
            if (st_q.idx == IX_ADR_LO &&
                st_q.slots[SLOT_CTRL][NW-1:1] == MODE_STORE) begin
                ram_we = 1'b1;
            end
        end
        ram_waddr = {st_d.slots[SLOT_CTRL][0], st_d.slots[SLOT_ADR_LO]};
        ram_wdata = {st_q.slots[SLOT_DAT_HI], st_q.slots[SLOT_DAT_LO]};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign idx_o   = st_q.idx;
    assign bank_o  = {st_q.slots[SLOT_BANK_HI], st_q.slots[SLOT_BANK_LO]};
    assign ctrl_o  = st_q.slots[SLOT_CTRL];
    assign raddr_o = {st_q.slots[SLOT_CTRL][0], st_q.slots[SLOT_ADR_LO]};

    // R3
    idx_load_chk: assert property (@(posedge clk) disable iff (rst)
        idx_wr |=> idx_o == $past(wdata));

    // R4
    high_index_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && !idx_wr && idx_o >= REG_LIM) |=> $stable(st_q.slots));

    // R5
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(dat_wr && !idx_wr && idx_o <= IW'(1)) |=> $stable(bank_o));
endmodule

// File: rtl/nibmap_sram.sv
module nibmap_sram
    import nibmap_pkg::*;
#(
    parameter int unsigned AW = SRAM_AW,
    parameter int unsigned DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DEPTH-1:0][DW-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) mem_q <= '0;
        else     mem_q <= mem_d;
    end

    assign rdata = mem_q[raddr];

    // R7
    sram_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mem_q));
endmodule

// File: rtl/nibmap_readback.sv
module nibmap_readback
    import nibmap_pkg::*;
#(
    parameter int unsigned NW = NIB_W,
    parameter int unsigned IW = BYTE_W
) (
    input  logic            odd,
    input  logic [IW-1:0]   idx,
    input  logic [NW-1:0]   ctrl,
    input  logic [2*NW-1:0] ram_byte,
    output logic [IW-1:0]   rdata
);
    logic          fetch_mode;
    logic [NW-1:0] nib;

    always_comb begin
        fetch_mode = (ctrl[NW-1:1] == MODE_FETCH);
        nib        = '0;
        if (odd) begin
            rdata = RD_IDX_PORT;
        end else begin
            unique case (idx)
                IX_RD_LO, IX_RD_HI: begin
                    if (fetch_mode)
                        nib = (idx == IX_RD_HI) ? ram_byte[2*NW-1:NW] : ram_byte[NW-1:0];
                    rdata = RD_PAD | IW'(nib);
                end
                IX_STATUS: rdata = RD_STATUS;
                default:   rdata = RD_STATUS;
            endcase
        end
    end
endmodule

// File: rtl/nibble_mapper.sv
module nibble_mapper
    import nibmap_pkg::*;
#(
    parameter int unsigned AW = BUS_AW,
    parameter int unsigned DW = BYTE_W,
    parameter int unsigned NW = NIB_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [DW-1:0] rom_bank
);
    localparam int unsigned RAW = NW + 1;

    logic            idx_wr, dat_wr;
    logic [DW-1:0]   idx;
    logic [NW-1:0]   ctrl;
    logic [RAW-1:0]  raddr, waddr;
    logic            ram_we;
    logic [2*NW-1:0] ram_wdata, ram_rdata;

    nibmap_decode #(.AW(AW)) u_dec (
        .we(bus_we), .addr(bus_addr), .idx_wr(idx_wr), .dat_wr(dat_wr)
    );

    nibmap_regfile #(.NW(NW), .IW(DW), .NREG(REG_NUM)) u_rf (
        .clk(clk), .rst(rst), .idx_wr(idx_wr), .dat_wr(dat_wr),
        .wdata(bus_wdata), .idx_o(idx), .bank_o(rom_bank), .ctrl_o(ctrl),
        .raddr_o(raddr), .ram_we(ram_we), .ram_waddr(waddr),
        .ram_wdata(ram_wdata)
    );

    nibmap_sram #(.AW(RAW), .DW(2*NW)) u_ram (
        .clk(clk), .rst(rst), .we(ram_we), .waddr(waddr), .wdata(ram_wdata),
        .raddr(raddr), .rdata(ram_rdata)
    );

    nibmap_readback #(.NW(NW), .IW(DW)) u_rb (
        .odd(bus_addr[0]), .idx(idx), .ctrl(ctrl), .ram_byte(ram_rdata),
        .rdata(bus_rdata)
    );

    // R8
    odd_port_ff_chk: assert property (@(posedge clk) disable iff (rst)
        bus_addr[0] |-> bus_rdata == 8'hFF);

    // R9
    pad_ones_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[7:4] == 4'hF);

    // R2
    outside_no_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[15:13] != 3'b101) |=> $stable(idx));
endmodule

// File: tb/nibble_mapper_test.sv
module nibble_mapper_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata, rom_bank;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] ram_m [32];

    localparam logic [15:0] IDX_PORT = 16'hA001;
    localparam logic [15:0] DAT_PORT = 16'hA000;

    always #2 clk = ~clk;

    nibble_mapper uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rom_bank(rom_bank)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = DAT_PORT;
    endtask

    task automatic put(input logic [7:0] slot, input logic [7:0] d);
        wr(IDX_PORT, slot);
        wr(DAT_PORT, d);
    endtask

    task automatic rd(input logic [7:0] ix, input logic odd, output logic [7:0] v);
        wr(IDX_PORT, ix);
        bus_addr = odd ? IDX_PORT : DAT_PORT;
        #1 v = bus_rdata;
    endtask

    task automatic ram_store(input logic [4:0] a, input logic [7:0] d);
        put(8'h4, {4'h0, d[3:0]});
        put(8'h5, {4'h0, d[7:4]});
        put(8'h6, {7'b0, a[4]});
        put(8'h7, {4'h0, a[3:0]});
    endtask

    task automatic ram_point(input logic [4:0] a);
        put(8'h6, {7'b0000001, a[4]});
        put(8'h7, {4'h0, a[3:0]});
    endtask

    task automatic reset_test;
        logic [7:0] v;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) ram_m[i] = 8'h00;
        chk("R1 bank after reset", rom_bank, 8'h00);
        rd(8'h0C, 1'b0, v);
        chk("R1 store mode read after reset", v, 8'hF0);
        ram_point(5'h00);
        rd(8'h0D, 1'b0, v);
        chk("R1 ram cleared", v, 8'hF0);
    endtask

    task automatic bank_test;
        put(8'h0, 8'h05);
        chk("R5 bank low only", rom_bank, 8'h05);
        put(8'h1, 8'h3A);
        chk("R5 R4 bank high nibble, upper bits dropped", rom_bank, 8'hA5);
        put(8'h4, 8'h09);
        chk("R5 bank unaffected by slot 4", rom_bank, 8'hA5);
    endtask

    task automatic decode_test;
        wr(16'hC001, 8'h00);
        wr(16'hC000, 8'h0F);
        chk("R2 write outside region", rom_bank, 8'hA5);
        wr(16'h8001, 8'h01);
        wr(16'h8000, 8'h0E);
        chk("R2 write region 100", rom_bank, 8'hA5);
        wr(16'hBFFF, 8'h00);
        wr(16'hBFFE, 8'h02);
        chk("R3 R2 index via any odd address in region", rom_bank, 8'hA2);
    endtask

    task automatic index_limit_test;
        put(8'h08, 8'h07);
        chk("R4 index 8 ignored", rom_bank, 8'hA2);
        put(8'h10, 8'h06);
        chk("R4 index 0x10 ignored", rom_bank, 8'hA2);
        put(8'h81, 8'h01);
        chk("R4 index 0x81 ignored", rom_bank, 8'hA2);
    endtask

    task automatic ram_test;
        logic [4:0] addrs [4] = '{5'h00, 5'h0F, 5'h10, 5'h1F};
        logic [7:0] datas [4] = '{8'h3C, 8'hA5, 8'h96, 8'h1E};
        logic [7:0] v;
        for (int i = 0; i < 4; i++) begin
            ram_store(addrs[i], datas[i]);
            ram_m[addrs[i]] = datas[i];
        end
        for (int i = 0; i < 4; i++) begin
            ram_point(addrs[i]);
            rd(8'h0C, 1'b0, v);
            chk("R6 R10 low nibble", v, 8'hF0 | {4'h0, ram_m[addrs[i]][3:0]});
            rd(8'h0D, 1'b0, v);
            chk("R6 R10 high nibble", v, 8'hF0 | {4'h0, ram_m[addrs[i]][7:4]});
        end
    endtask

    task automatic no_commit_test;
        logic [7:0] v;
        put(8'h4, 8'h07);
        put(8'h5, 8'h07);
        ram_point(5'h0F);
        rd(8'h0C, 1'b0, v);
        chk("R7 fetch-mode commit keeps low", v, 8'hF5);
        rd(8'h0D, 1'b0, v);
        chk("R7 fetch-mode commit keeps high", v, 8'hFA);
        put(8'h6, 8'h04);
        put(8'h7, 8'h0F);
        rd(8'h0C, 1'b0, v);
        chk("R10 undefined mode reads pad", v, 8'hF0);
        put(8'h6, 8'h00);
        put(8'h4, 8'h02);
        put(8'h5, 8'h08);
        put(8'h6, 8'h02);
        rd(8'h0C, 1'b0, v);
        chk("R7 undefined mode commit and slots 4-6 keep low", v, 8'hF5);
        rd(8'h0D, 1'b0, v);
        chk("R7 undefined mode commit and slots 4-6 keep high", v, 8'hFA);
    endtask

    task automatic status_test;
        logic [7:0] v;
        rd(8'h0A, 1'b0, v);
        chk("R9 status index", v, 8'hF1);
        rd(8'h03, 1'b0, v);
        chk("R9 slot index reads status", v, 8'hF1);
        rd(8'hFF, 1'b0, v);
        chk("R9 unknown index", v, 8'hF1);
        rd(8'h1C, 1'b0, v);
        chk("R9 index 0x1C not a selector", v, 8'hF1);
    endtask

    task automatic odd_port_test;
        logic [7:0] v;
        rd(8'h0C, 1'b1, v);
        chk("R8 odd read with selector index", v, 8'hFF);
        rd(8'h0A, 1'b1, v);
        chk("R8 odd read with status index", v, 8'hFF);
    endtask

    initial begin
        reset_test();
        bank_test();
        decode_test();
        index_limit_test();
        ram_test();
        no_commit_test();
        status_test();
        odd_port_test();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule